// File: doc/BRIEF.md
# Packed byte rounding-average unit

This execution unit accepts one instruction per clock carrying a small opcode and two 64-bit source words. Each word is viewed as eight unsigned byte lanes. For the average opcode, every lane of the result holds the rounded mean of the matching lanes of the two sources, computed as (a + b + 1) >> 1 with the carry of the byte addition kept, so no lane can overflow. Any other opcode copies source A to the result unchanged. Copying A makes it easy to confirm that the lanes stay isolated.

The unit is gated by a mode-enable input, which is taken from the processor's extended-mode status bit. When an instruction is accepted while the mode is off, the unit writes no result and raises an illegal-instruction flag for one cycle. Each accepted and enabled instruction produces a registered result on the following clock. Alongside the result, the unit reports the address step, in bytes, that a post-increment or pre-decrement memory operand of this size would apply.

Top module: `lane_avg_unit`

## Requirements
- R1: While `rst` is high, on every clock `resValid`, `illegalTrap` and `issueReady` are 0, `resData` is all zeros and `resStep` is 0.
- R2: With opcode 2'b01 (average), each byte lane i (bits 8i+7..8i) of `resData` equals (a_i + b_i + 1) >> 1 of the same lanes of `opA` and `opB`, treated as unsigned.
- R3: The lane sum keeps its carry. 0xFF averaged with 0xFF gives 0xFF, 0x00 with 0x01 gives 0x01, and 0xFE with 0x01 gives 0x80. No lane affects another lane.
- R4: The wide-sum form (AVG_FORM=0) and the carry-free form (AVG_FORM=1) give identical results for every operand pair. The carry-free form is (a>>1) + (b>>1) + ((a|b) & 1) per lane.
- R5: An issue accepted while `modeEn` is 0 sets `illegalTrap` to 1 and `resValid` to 0 in the next cycle, and leaves `resData` unchanged.
- R6: An issue accepted while `modeEn` is 1 sets `resValid` to 1 and `illegalTrap` to 0 in the next cycle. Back-to-back issues give one result per clock.
- R7: Any opcode other than 2'b01 (2'b00, 2'b10, 2'b11) loads `opA` into `resData` unchanged.
- R8: `resStep` is 8 (the operand size in bytes) in every cycle where `resValid` is 1, and 0 otherwise.
- R9: A cycle with `issueValid` low gives `resValid` 0 and `illegalTrap` 0 in the next cycle, and `resData` holds its value.
- R10: `issueReady` is 1 from the first clock after `rst` falls, and stays 1 for as long as reset is low. An issue is accepted when `issueValid` and `issueReady` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | Instruction present |
| issueReady | output | 1 | Unit accepts an instruction this cycle |
| issueOp | input | 2 | Opcode: 2'b01 average, others pass A |
| opA | input | 64 | Source word A, eight byte lanes |
| opB | input | 64 | Source word B, eight byte lanes |
| modeEn | input | 1 | Extended-mode enable from the status register |
| resValid | output | 1 | Result written this cycle |
| resData | output | 64 | Result word |
| resStep | output | 4 | Address step in bytes for the operand |
| illegalTrap | output | 1 | Illegal-instruction flag |

## Verification
The bench builds two copies of the unit from the same stimulus. One uses the default wide-sum lane adder (AVG_FORM=0) and the other uses the carry-free form (AVG_FORM=1), both with eight 8-bit lanes. Comparing both against one per-byte model checks that the two lane forms agree on every vector, including the carry corners 0xFF/0xFF and 0xFE/0x01. It also covers the cases where a carry leaking across lanes would show up. The mode gate, the pass opcodes, idle cycles and long back-to-back runs are checked on the same two builds.

// File: rtl/lane_avg_pkg.sv
package lane_avg_pkg;

  localparam int OPC_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_PASS0 = 2'b00,
    OPC_AVG   = 2'b01,
    OPC_PASS2 = 2'b10,
    OPC_PASS3 = 2'b11
  } avg_opc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRes;
    logic selAvg;
  } avg_strobe_t;

endpackage

// File: rtl/lane_avg_lane.sv
module lane_avg_lane #(
  parameter int LANE_W   = 8,
  parameter int AVG_FORM = 0
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  output logic [LANE_W-1:0] laneAvg
);

  localparam logic [LANE_W:0]   ONE_W = {{LANE_W{1'b0}}, 1'b1};
  localparam logic [LANE_W-1:0] LSB_M = {{(LANE_W-1){1'b0}}, 1'b1};

  logic [LANE_W:0]   wideSum;
  logic [LANE_W-1:0] halfA;
  logic [LANE_W-1:0] halfB;
  logic [LANE_W-1:0] roundBit;

  assign wideSum  = {1'b0, laneA} + {1'b0, laneB} + ONE_W;
  assign halfA    = laneA >> 1;
  assign halfB    = laneB >> 1;
  assign roundBit = (laneA | laneB) & LSB_M;

  generate
    if (AVG_FORM == 0) begin : g_wide
      assign laneAvg = wideSum[LANE_W:1];
    end else begin : g_carry_free
      assign laneAvg = halfA + halfB + roundBit;
    end
  endgenerate

  // R4: whichever form is built, it must match the other one
  always_comb begin
    a_r4_forms_agree: assert (wideSum[LANE_W:1] == halfA + halfB + roundBit)
      else $error("lane forms disagree");
  end

endmodule

// File: rtl/lane_avg_ctrl.sv
module lane_avg_ctrl
  import lane_avg_pkg::*;
#(
  parameter int STEP_BYTES = 8,
  parameter int STEP_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  input  logic [OPC_W-1:0]  issueOp,
  input  logic              modeEn,
  output logic              issueReady,
  output logic              resValid,
  output logic              illegalTrap,
  output logic [STEP_W-1:0] resStep,
  output avg_strobe_t       strb
);

  localparam logic [STEP_W-1:0] STEP_VAL = STEP_W'(STEP_BYTES);

  logic readyQ;
  logic accepted;

  assign issueReady = readyQ;
  assign accepted   = issueValid && readyQ;

  always_comb begin
    strb.loadRes = accepted && modeEn;
    strb.selAvg  = (issueOp == OPC_AVG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ      <= 1'b0;
      resValid    <= 1'b0;
      illegalTrap <= 1'b0;
      resStep     <= '0;
    end else begin
      readyQ      <= 1'b1;
      resValid    <= strb.loadRes;
      illegalTrap <= accepted && !modeEn;
      resStep     <= strb.loadRes ? STEP_VAL : '0;
    end
  end

  a_r5_trap_on_disabled: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueReady && !modeEn) |=> (illegalTrap && !resValid));

  a_r6_result_next_cycle: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueReady && modeEn) |=> (resValid && !illegalTrap));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !issueValid |=> (!resValid && !illegalTrap));

  a_r10_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    !rst |=> issueReady);

  a_r8_step_with_valid: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resStep == STEP_VAL));

endmodule

// File: rtl/lane_avg_dp.sv
module lane_avg_dp
  import lane_avg_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter int AVG_FORM = 0,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  avg_strobe_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resData
);

  logic [DATA_W-1:0] avgWord;
  logic [DATA_W-1:0] resQ;

  generate
    for (genvar li = 0; li < LANES; li++) begin : g_lane
      lane_avg_lane #(
        .LANE_W  (LANE_W),
        .AVG_FORM(AVG_FORM)
      ) u_lane (
        .laneA  (opA[li*LANE_W +: LANE_W]),
        .laneB  (opB[li*LANE_W +: LANE_W]),
        .laneAvg(avgWord[li*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      resQ <= '0;
    end else if (strb.loadRes) begin
      resQ <= strb.selAvg ? avgWord : opA;
    end
  end

  assign resData = resQ;

  a_r5_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !strb.loadRes |=> $stable(resQ));

endmodule

// File: rtl/lane_avg_unit.sv
module lane_avg_unit
  import lane_avg_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter int AVG_FORM = 0,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int STEP_BY = DATA_W / 8,
  localparam int STEP_W  = $clog2(STEP_BY) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [OPC_W-1:0]  issueOp,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              modeEn,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [STEP_W-1:0] resStep,
  output logic              illegalTrap
);

  avg_strobe_t strb;

  lane_avg_ctrl #(
    .STEP_BYTES(STEP_BY),
    .STEP_W    (STEP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .issueOp    (issueOp),
    .modeEn     (modeEn),
    .issueReady (issueReady),
    .resValid   (resValid),
    .illegalTrap(illegalTrap),
    .resStep    (resStep),
    .strb       (strb)
  );

  lane_avg_dp #(
    .LANES   (LANES),
    .LANE_W  (LANE_W),
    .AVG_FORM(AVG_FORM)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .resData(resData)
  );

  a_r5_no_valid_with_trap: assert property (@(posedge clk) disable iff (rst)
    !(resValid && illegalTrap));

endmodule

// File: tb/lane_avg_unit_bench.sv
module lane_avg_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issueValid = 1'b0;
  logic [1:0]  issueOp = 2'b00;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        modeEn = 1'b0;

  logic        rdy0, val0, trp0, rdy1, val1, trp1;
  logic [63:0] dat0, dat1;
  logic [3:0]  stp0, stp1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // model state
  bit          expReady = 0;
  bit          expValid = 0;
  bit          expTrap = 0;
  logic [63:0] expData = '0;
  int          expStep = 0;

  always #5 clk = ~clk;

  lane_avg_unit #(.AVG_FORM(0)) u_lane_avg_unit (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueReady(rdy0),
    .issueOp(issueOp), .opA(opA), .opB(opB), .modeEn(modeEn),
    .resValid(val0), .resData(dat0), .resStep(stp0), .illegalTrap(trp0));

  lane_avg_unit #(.AVG_FORM(1)) u_lane_avg_unit_cf (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueReady(rdy1),
    .issueOp(issueOp), .opA(opA), .opB(opB), .modeEn(modeEn),
    .resValid(val1), .resData(dat1), .resStep(stp1), .illegalTrap(trp1));

  function automatic logic [63:0] refAvg(logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      int x, y;
      x = int'(a[i*8 +: 8]);
      y = int'(b[i*8 +: 8]);
      r[i*8 +: 8] = 8'((x + y + 1) / 2);
    end
    return r;
  endfunction

  task automatic checkOne(string tag, string inst, bit v, bit t, bit r,
                          logic [63:0] d, logic [3:0] s);
    vectors++;
    if (v !== expValid) begin
      miscompares++;
      $display("FAIL %s %s resValid got %0b exp %0b", tag, inst, v, expValid);
    end
    if (t !== expTrap) begin
      miscompares++;
      $display("FAIL %s %s illegalTrap got %0b exp %0b", tag, inst, t, expTrap);
    end
    if (r !== expReady) begin
      miscompares++;
      $display("FAIL %s %s issueReady got %0b exp %0b", tag, inst, r, expReady);
    end
    if (d !== expData) begin
      miscompares++;
      $display("FAIL %s %s resData got %h exp %h", tag, inst, d, expData);
    end
    if (int'(s) != expStep) begin
      miscompares++;
      $display("FAIL %s %s resStep got %0d exp %0d", tag, inst, s, expStep);
    end
  endtask

  task automatic checkBoth(string tag);
    checkOne(tag, "wide", val0, trp0, rdy0, dat0, stp0);
    checkOne(tag, "carryfree", val1, trp1, rdy1, dat1, stp1);
  endtask

  // drive at negedge, model the next edge, compare at the following negedge
  task automatic step(string tag, bit v, logic [1:0] op,
                      logic [63:0] a, logic [63:0] b, bit me);
    bit acc;
    issueValid = v; issueOp = op; opA = a; opB = b; modeEn = me;
    acc = v && expReady;
    if (acc && me) begin
      expValid = 1; expTrap = 0; expStep = 8;
      expData = (op == 2'b01) ? refAvg(a, b) : a;
    end else begin
      expValid = 0; expTrap = acc; expStep = 0;
    end
    expReady = 1;
    @(posedge clk);
    @(negedge clk);
    checkBoth(tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [63:0] ra, rb;
    // R1: reset state, with an issue presented during reset
    issueValid = 1; issueOp = 2'b01; opA = '1; opB = '1; modeEn = 1;
    repeat (3) @(negedge clk);
    checkBoth("R1");
    rst = 0;
    // R10: first cycle out of reset, idle
    step("R10", 0, 2'b01, '0, '0, 1);
    // R2 / R3 corner operands
    step("R3", 1, 2'b01, 64'h0, 64'h0, 1);
    step("R3", 1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    step("R3", 1, 2'b01, 64'h0001_0001_0001_0001, 64'h0100_0100_0100_0100, 1);
    step("R3", 1, 2'b01, 64'h01FE_01FE_01FE_01FE, 64'hFE01_FE01_FE01_FE01, 1);
    step("R4", 1, 2'b01, 64'hFF00_FF00_FF00_FF00, 64'hFF01_00FF_01FE_7F80, 1);
    step("R2", 1, 2'b01, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1);
    // R7: pass opcodes
    step("R7", 1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1);
    step("R7", 1, 2'b10, 64'h8000_0000_0000_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    step("R7", 1, 2'b11, 64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, 1);
    // R5: mode disabled, data must hold
    step("R5", 1, 2'b01, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0);
    step("R5", 1, 2'b00, 64'hDEAD_BEEF_0000_0000, 64'h0, 0);
    // R9: idle holds
    step("R9", 0, 2'b01, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1);
    // R8 / R6: result with step, then back-to-back random
    step("R8", 1, 2'b01, 64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0, 1);
    for (int n = 0; n < 400; n++) begin
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      step("R6", ($urandom() % 8) != 0, 2'($urandom() % 4), ra, rb,
           ($urandom() % 6) != 0);
    end
    for (int n = 0; n < 100; n++) begin
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      step("R4", 1, 2'b01, ra, rb, 1);
    end
    // R1 again: reset mid-run clears everything
    rst = 1;
    expReady = 0; expValid = 0; expTrap = 0; expData = '0; expStep = 0;
    @(posedge clk);
    @(negedge clk);
    checkBoth("R1");
    finish();
  end

endmodule